// File: doc/BRIEF.md
# ADC Start-of-Conversion Sequencer

This block schedules conversions for a bank of sixteen conversion slots that share one dual sample-and-hold converter. Each slot is configured with a channel select, the trigger line that starts it and an acquisition length. A rising edge on a slot's trigger line marks that slot pending. The sequencer serves pending slots one at a time, lowest slot number first. For each slot it opens an acquisition window in which both sample capacitors are routed to the selected input index. It then asks an external converter for a result through a start/done handshake, stores the returned value in the slot's result register and emits a one-clock end-of-conversion (EOC) pulse.

Adjacent even/odd slots can be coupled. When a pair is coupled, a trigger on either member samples the A and B inputs of one index in a single window. The A sample is converted first and lands in the even slot's register and EOC. The B sample follows and lands in the odd slot's register and EOC. The analog core is outside the block, as are trigger source mapping and interrupt aggregation.

Top module: `adc_soc_sequencer`

## Requirements
- R1: A slot becomes pending on a rising edge of trig_in[t], where t is the slot's 4-bit trigger select. A trigger line held high for several cycles produces exactly one conversion.
- R2: Pending slots are served one at a time, lowest-numbered slot first.
- R3: The acquisition window holds samp_active high for exactly cfg_acq+1 consecutive cycles. During the window samp_idx equals bits 2:0 of the served slot's channel select and stays constant; no conv_start occurs inside a window.
- R4: In sequential mode a served slot produces one conv_start, with conv_sel_b equal to bit 3 of its channel select (1 = B side). The returned conv_data is written to that slot's result field, result[s*12 +: 12]. A result field changes only in the cycle after conv_done.
- R5: In coupled mode (cfg_pair_en[s/2] = 1), a trigger on either slot of the pair runs one acquisition window on index chsel[2:0] of the triggered slot, ignoring chsel[3]. It then issues two conversions, A (conv_sel_b = 0) first and B second.
- R6: In coupled mode the A result goes to the even slot's result field and EOC bit, and the B result goes to the odd slot's result field and EOC bit.
- R7: Each EOC is a one-clock pulse on the bit of the slot whose result it reports. With cfg_eoc_late = 0 it appears in the cycle after that conversion's conv_start. With cfg_eoc_late = 1 it appears in the cycle after its conv_done, the same cycle the result field shows the new value.
- R8: If both slots of a coupled pair are triggered, each runs its own paired conversion into the same two result fields, and the later run's values remain.
- R9: A trigger edge for a slot that is already pending sets ovf[s] and adds no conversion. ovf[s] stays high until the slot is taken into service.
- R10: conv_start is a one-cycle pulse, and no new conv_start is issued until conv_done has answered the previous one.
- R11: After reset all result fields, eoc, ovf, samp_active and conv_start are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 16 | Trigger lines, edge sensitive |
| cfg_chsel | input | 64 | Per-slot channel select, 4 bits each (bit 3 = B side, bits 2:0 = index) |
| cfg_trigsel | input | 64 | Per-slot trigger line number, 4 bits each |
| cfg_acq | input | 96 | Per-slot acquisition length, 6 bits each (window = value + 1 cycles) |
| cfg_pair_en | input | 8 | Coupling enable per even/odd slot pair |
| cfg_eoc_late | input | 1 | EOC position: 0 at conversion start, 1 at completion |
| samp_active | output | 1 | Both sample capacitors connected |
| samp_idx | output | 3 | Input index both capacitors are routed to |
| conv_start | output | 1 | One-cycle conversion request |
| conv_sel_b | output | 1 | Capacitor to convert with conv_start (1 = B) |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| result | output | 192 | Per-slot result registers, 12 bits each |
| eoc | output | 16 | Per-slot end-of-conversion pulses |
| ovf | output | 16 | Per-slot trigger overflow flags |

## Verification
The hardest state to reach from the ports is a coupled pair in which both members were triggered. The two runs queue behind one another and race for the same two result fields. Only the order of the four EOC pulses and the surviving values show that both runs happened and that the later one won. The bench reaches this state by giving both slots of one pair the same trigger line, so that a single edge marks both pending in one cycle. It gives the two slots different indices and reads the index the converter stub encodes into each result. The overflow case is reached in a similar way: a long acquisition on slot 0 keeps slot 7 waiting while its trigger line toggles twice.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int CHSEL_W = 4;
    localparam int IDX_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_START,
        ST_WAIT
    } seq_state_t;

    typedef struct packed {
        logic             side_b;
        logic [IDX_W-1:0] idx;
    } chan_t;

    function automatic chan_t decode_chsel(input logic [CHSEL_W-1:0] raw);
        chan_t c;
        c.side_b = raw[CHSEL_W-1];
        c.idx    = raw[IDX_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/adcseq_trig_latch.sv
module adcseq_trig_latch #(
    parameter int NUM_SLOTS = 16,
    parameter int TSEL_W    = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int NUM_TRIG = 1 << TSEL_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_TRIG-1:0]         trig_in,
    input  logic [NUM_SLOTS*TSEL_W-1:0] cfg_trigsel,
    input  logic                        accept,
    input  logic [SLOT_W-1:0]           accept_slot,
    output logic [NUM_SLOTS-1:0]        pending,
    output logic [NUM_SLOTS-1:0]        ovf
);
    logic [NUM_TRIG-1:0]  trig_q;
    logic [NUM_TRIG-1:0]  rise;
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] taken;

    assign rise = trig_in & ~trig_q;

    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            hit[s]   = rise[cfg_trigsel[s*TSEL_W +: TSEL_W]];
            taken[s] = accept && (accept_slot == SLOT_W'(s));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= '0;
            pending <= '0;
            ovf     <= '0;
        end else begin
            trig_q  <= trig_in;
            pending <= (pending & ~taken) | hit;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (hit[s] && pending[s] && !taken[s])
                    ovf[s] <= 1'b1;
                else if (taken[s])
                    ovf[s] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adcseq_pick.sv
module adcseq_pick #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] pending,
    output logic                 valid,
    output logic [SLOT_W-1:0]    slot
);
    always_comb begin
        valid = |pending;
        slot  = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (pending[s])
                slot = SLOT_W'(s);
        end
    end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int ACQ_W     = 6,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_valid,
    input  logic [SLOT_W-1:0] pend_slot,
    input  chan_t             sel_chan,
    input  logic [ACQ_W-1:0]  sel_acq,
    input  logic              sel_pair,
    input  logic              eoc_late,
    input  logic              conv_done,
    output logic              accept,
    output logic              samp_active,
    output logic [IDX_W-1:0]  samp_idx,
    output logic              conv_start,
    output logic              conv_sel_b,
    output logic              wr_en,
    output logic              ev_fire,
    output logic [SLOT_W-1:0] tgt_slot
);
    seq_state_t        state;
    logic [ACQ_W-1:0]  cnt;
    logic [SLOT_W-1:0] cur_slot;
    chan_t             cur_chan;
    logic              paired;
    logic              second;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_slot <= '0;
            cur_chan <= '0;
            paired   <= 1'b0;
            second   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pend_valid) begin
                        cur_slot <= pend_slot;
                        cur_chan <= sel_chan;
                        paired   <= sel_pair;
                        second   <= 1'b0;
                        cnt      <= sel_acq;
                        state    <= ST_ACQ;
                    end
                end
                ST_ACQ: begin
                    if (cnt == '0)
                        state <= ST_START;
                    else
                        cnt <= cnt - 1'b1;
                end
                ST_START: state <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) begin
                        if (paired && !second) begin
                            second <= 1'b1;
                            state  <= ST_START;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept      = (state == ST_IDLE) && pend_valid;
        samp_active = (state == ST_ACQ);
        samp_idx    = cur_chan.idx;
        conv_start  = (state == ST_START);
        conv_sel_b  = paired ? second : cur_chan.side_b;
        tgt_slot    = paired ? {cur_slot[SLOT_W-1:1], second} : cur_slot;
        wr_en       = (state == ST_WAIT) && conv_done;
        ev_fire     = (conv_start && !eoc_late) || (wr_en && eoc_late);
    end
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results #(
    parameter int NUM_SLOTS = 16,
    parameter int RES_W     = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic [RES_W-1:0]           wr_data,
    output logic [NUM_SLOTS*RES_W-1:0] result
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                result[s*RES_W +: RES_W] <= '0;
            else if (wr_en && (wr_slot == SLOT_W'(s)))
                result[s*RES_W +: RES_W] <= wr_data;
        end
    end
endmodule

// File: rtl/adc_soc_sequencer.sv
module adc_soc_sequencer
    import adcseq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int TSEL_W    = 4,
    parameter int ACQ_W     = 6,
    parameter int RES_W     = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int NUM_TRIG = 1 << TSEL_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_TRIG-1:0]         trig_in,
    input  logic [NUM_SLOTS*CHSEL_W-1:0] cfg_chsel,
    input  logic [NUM_SLOTS*TSEL_W-1:0] cfg_trigsel,
    input  logic [NUM_SLOTS*ACQ_W-1:0]  cfg_acq,
    input  logic [NUM_SLOTS/2-1:0]      cfg_pair_en,
    input  logic                        cfg_eoc_late,
    output logic                        samp_active,
    output logic [IDX_W-1:0]            samp_idx,
    output logic                        conv_start,
    output logic                        conv_sel_b,
    input  logic                        conv_done,
    input  logic [RES_W-1:0]            conv_data,
    output logic [NUM_SLOTS*RES_W-1:0]  result,
    output logic [NUM_SLOTS-1:0]        eoc,
    output logic [NUM_SLOTS-1:0]        ovf
);
    logic [NUM_SLOTS-1:0] pending;
    logic                 pend_valid;
    logic [SLOT_W-1:0]    pend_slot;
    logic                 accept;
    logic                 wr_en;
    logic                 ev_fire;
    logic [SLOT_W-1:0]    tgt_slot;
    chan_t                sel_chan;
    logic [ACQ_W-1:0]     sel_acq;
    logic                 sel_pair;

    adcseq_trig_latch #(.NUM_SLOTS(NUM_SLOTS), .TSEL_W(TSEL_W)) trig_i (
        .clk        (clk),
        .rst        (rst),
        .trig_in    (trig_in),
        .cfg_trigsel(cfg_trigsel),
        .accept     (accept),
        .accept_slot(pend_slot),
        .pending    (pending),
        .ovf        (ovf)
    );

    adcseq_pick #(.NUM_SLOTS(NUM_SLOTS)) pick_i (
        .pending(pending),
        .valid  (pend_valid),
        .slot   (pend_slot)
    );

    always_comb begin
        sel_chan = decode_chsel(cfg_chsel[pend_slot*CHSEL_W +: CHSEL_W]);
        sel_acq  = cfg_acq[pend_slot*ACQ_W +: ACQ_W];
        sel_pair = cfg_pair_en[pend_slot[SLOT_W-1:1]];
    end

    adcseq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .ACQ_W(ACQ_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .pend_valid (pend_valid),
        .pend_slot  (pend_slot),
        .sel_chan   (sel_chan),
        .sel_acq    (sel_acq),
        .sel_pair   (sel_pair),
        .eoc_late   (cfg_eoc_late),
        .conv_done  (conv_done),
        .accept     (accept),
        .samp_active(samp_active),
        .samp_idx   (samp_idx),
        .conv_start (conv_start),
        .conv_sel_b (conv_sel_b),
        .wr_en      (wr_en),
        .ev_fire    (ev_fire),
        .tgt_slot   (tgt_slot)
    );

    adcseq_results #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) res_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_slot(tgt_slot),
        .wr_data(conv_data),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst)
            eoc <= '0;
        else
            eoc <= ev_fire ? (NUM_SLOTS'(1) << tgt_slot) : '0;
    end
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
    parameter int NUM_SLOTS = 16,
    parameter int RES_W     = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       samp_active,
    input logic [2:0]                 samp_idx,
    input logic                       conv_start,
    input logic                       conv_done,
    input logic                       cfg_eoc_late,
    input logic [NUM_SLOTS*RES_W-1:0] result,
    input logic [NUM_SLOTS-1:0]       eoc
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else if (conv_start)
            busy_q <= 1'b1;
        else if (conv_done)
            busy_q <= 1'b0;
    end

    p_start_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !busy_q);

    p_idx_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (samp_active && $past(samp_active)) |-> $stable(samp_idx));

    p_no_start_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !samp_active);

    p_eoc_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eoc));

    p_eoc_early_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_start) && !$past(cfg_eoc_late)) |-> (eoc != '0));

    p_eoc_late_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_done) && $past(busy_q) && $past(cfg_eoc_late)) |-> (eoc != '0));

    p_result_on_done_r4: assert property (@(posedge clk) disable iff (rst)
        (result != $past(result)) |-> $past(conv_done));
endmodule

bind adc_soc_sequencer adcseq_checker #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .samp_active (samp_active),
    .samp_idx    (samp_idx),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .cfg_eoc_late(cfg_eoc_late),
    .result      (result),
    .eoc         (eoc)
);

// File: tb/adc_soc_sequencer_tb_top.sv
module adc_soc_sequencer_tb_top;
    localparam int NS = 16;
    localparam int RW = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     trig_in = '0;
    logic [NS*4-1:0] cfg_chsel = '0;
    logic [NS*4-1:0] cfg_trigsel = '1;
    logic [NS*6-1:0] cfg_acq = '0;
    logic [NS/2-1:0] cfg_pair_en = '0;
    logic            cfg_eoc_late = 1'b0;
    logic            samp_active;
    logic [2:0]      samp_idx;
    logic            conv_start;
    logic            conv_sel_b;
    logic            conv_done = 1'b0;
    logic [RW-1:0]   conv_data = '0;
    logic [NS*RW-1:0] result;
    logic [NS-1:0]   eoc;
    logic [NS-1:0]   ovf;

    int checks = 0;
    int failures = 0;

    adc_soc_sequencer dut_i (
        .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_chsel(cfg_chsel),
        .cfg_trigsel(cfg_trigsel), .cfg_acq(cfg_acq), .cfg_pair_en(cfg_pair_en),
        .cfg_eoc_late(cfg_eoc_late), .samp_active(samp_active), .samp_idx(samp_idx),
        .conv_start(conv_start), .conv_sel_b(conv_sel_b), .conv_done(conv_done),
        .conv_data(conv_data), .result(result), .eoc(eoc), .ovf(ovf)
    );

    always #4 clk = ~clk;

    // converter stub and monitor
    int cyc = 0;
    int lat = 2;
    int wait_cnt = 0;
    bit outstanding = 0;
    logic [3:0] held_tag = '0;
    logic [7:0] serial = '0;
    int last_start = -10;
    int last_done = -10;
    int prev_start = -10;
    int hs_err = 0;
    int tm_err = 0;
    int n_conv = 0;
    int n_eoc = 0;
    int n_win = 0;
    int cur_len = 0;
    int win_len = 0;
    int win_idx = 0;
    int eoc_log[32];
    int side_log[32];
    int idx_log[32];

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (samp_active) begin
                if (cur_len == 0) win_idx = int'(samp_idx);
                cur_len++;
            end else if (cur_len > 0) begin
                win_len = cur_len;
                n_win++;
                cur_len = 0;
            end
            if (eoc != '0) begin
                for (int s = 0; s < NS; s++) begin
                    if (eoc[s]) begin
                        if (n_eoc < 32) eoc_log[n_eoc] = s;
                        n_eoc++;
                    end
                end
                if (cyc != (cfg_eoc_late ? last_done : last_start) + 1) tm_err++;
            end
            if (conv_start) begin
                if (outstanding || prev_start == cyc - 1) hs_err++;
                prev_start = cyc;
                last_start = cyc;
                outstanding = 1;
                wait_cnt = lat;
                held_tag = {conv_sel_b, samp_idx};
                if (n_conv < 32) begin
                    side_log[n_conv] = int'(conv_sel_b);
                    idx_log[n_conv] = int'(samp_idx);
                end
                n_conv++;
            end
        end
        conv_done = 1'b0;
        if (outstanding && !conv_start) begin
            wait_cnt--;
            if (wait_cnt <= 0) begin
                serial++;
                conv_done = 1'b1;
                conv_data = {held_tag, serial};
                outstanding = 0;
                last_done = cyc;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tag_of(input int s);
        return int'(result[s*RW+8 +: 4]);
    endfunction

    task automatic clear_logs();
        n_conv = 0; n_eoc = 0; n_win = 0; tm_err = 0; hs_err = 0;
    endtask

    task automatic cfg_default();
        cfg_chsel = '0; cfg_trigsel = '1; cfg_acq = '0; cfg_pair_en = '0;
        cfg_eoc_late = 1'b0; lat = 2;
    endtask

    task automatic set_slot(input int s, input logic [3:0] ch, input logic [3:0] tl,
                            input logic [5:0] acq);
        cfg_chsel[s*4 +: 4] = ch;
        cfg_trigsel[s*4 +: 4] = tl;
        cfg_acq[s*6 +: 6] = acq;
    endtask

    task automatic pulse(input int line, input int len);
        @(negedge clk);
        trig_in[line] = 1'b1;
        repeat (len) @(negedge clk);
        trig_in[line] = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 12) begin
            @(negedge clk); #1;
            if (!samp_active && !outstanding && !conv_start) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R11 result zero", int'(result != '0), 0);
        chk("R11 eoc zero", int'(eoc), 0);
        chk("R11 ovf zero", int'(ovf), 0);
        chk("R11 samp_active low", int'(samp_active), 0);
        chk("R11 conv_start low", int'(conv_start), 0);
    endtask

    task automatic t_single();
        cfg_default(); clear_logs();
        set_slot(3, 4'b1101, 4'd5, 6'd4);
        pulse(5, 5);
        wait_idle();
        chk("R1 held trigger converts once", n_conv, 1);
        chk("R3 window length", win_len, 5);
        chk("R3 window index", win_idx, 5);
        chk("R4 side B selected", side_log[0], 1);
        chk("R4 result tag slot3", tag_of(3), 4'hD);
        chk("R7 one eoc", n_eoc, 1);
        chk("R7 eoc slot", eoc_log[0], 3);
        chk("R7 early eoc timing", tm_err, 0);
        chk("R10 handshake", hs_err, 0);
    endtask

    task automatic t_order();
        cfg_default(); clear_logs();
        set_slot(9, 4'b0001, 4'd4, 6'd2);
        set_slot(2, 4'b1010, 4'd4, 6'd3);
        set_slot(6, 4'b0111, 4'd4, 6'd1);
        pulse(4, 1);
        wait_idle();
        chk("R2 three conversions", n_eoc, 3);
        chk("R2 first slot", eoc_log[0], 2);
        chk("R2 second slot", eoc_log[1], 6);
        chk("R2 third slot", eoc_log[2], 9);
        chk("R4 slot2 tag", tag_of(2), 4'hA);
        chk("R4 slot6 tag", tag_of(6), 4'h7);
        chk("R4 slot9 tag", tag_of(9), 4'h1);
    endtask

    task automatic t_pair_odd();
        cfg_default(); clear_logs();
        cfg_pair_en[2] = 1'b1;
        set_slot(5, 4'b1011, 4'd6, 6'd3);
        pulse(6, 1);
        wait_idle();
        chk("R5 single window", n_win, 1);
        chk("R5 window index", win_idx, 3);
        chk("R5 two conversions", n_conv, 2);
        chk("R5 A first", side_log[0], 0);
        chk("R5 B second", side_log[1], 1);
        chk("R6 even gets A", tag_of(4), 4'h3);
        chk("R6 odd gets B", tag_of(5), 4'hB);
        chk("R6 eoc even first", eoc_log[0], 4);
        chk("R6 eoc odd second", eoc_log[1], 5);
        chk("R10 handshake paired", hs_err, 0);
    endtask

    task automatic t_eoc_pos();
        cfg_default(); clear_logs();
        cfg_eoc_late = 1'b1; lat = 5;
        set_slot(1, 4'b0110, 4'd7, 6'd2);
        pulse(7, 1);
        wait_idle();
        chk("R7 late eoc timing", tm_err, 0);
        chk("R7 late eoc count", n_eoc, 1);
        clear_logs();
        cfg_eoc_late = 1'b0;
        pulse(7, 1);
        wait_idle();
        chk("R7 early eoc timing", tm_err, 0);
        chk("R7 early eoc count", n_eoc, 1);
    endtask

    task automatic t_pair_both();
        cfg_default(); clear_logs();
        cfg_pair_en[2] = 1'b1;
        set_slot(4, 4'b0001, 4'd2, 6'd1);
        set_slot(5, 4'b0110, 4'd2, 6'd1);
        pulse(2, 1);
        wait_idle();
        chk("R8 two windows", n_win, 2);
        chk("R8 four eoc", n_eoc, 4);
        chk("R8 eoc order 0", eoc_log[0], 4);
        chk("R8 eoc order 1", eoc_log[1], 5);
        chk("R8 eoc order 2", eoc_log[2], 4);
        chk("R8 eoc order 3", eoc_log[3], 5);
        chk("R8 even holds later A", tag_of(4), 4'h6);
        chk("R8 odd holds later B", tag_of(5), 4'hE);
    endtask

    task automatic t_overflow();
        cfg_default(); clear_logs();
        set_slot(0, 4'b0010, 4'd1, 6'd40);
        set_slot(7, 4'b0100, 4'd3, 6'd1);
        pulse(1, 1);
        pulse(3, 1);
        pulse(3, 1);
        @(negedge clk); #1;
        chk("R9 ovf set", int'(ovf[7]), 1);
        chk("R9 ovf only slot7", int'(ovf & ~16'h0080), 0);
        wait_idle();
        chk("R9 no extra conversion", n_conv, 2);
        chk("R9 ovf cleared on service", int'(ovf[7]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_single();
        t_order();
        t_pair_odd();
        t_eoc_pos();
        t_pair_both();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule